// File: doc/BRIEF.md
# Multi-Input Stream Arbiter

This block merges several valid/ready handshake input streams into a single output stream. Each input carries a payload word and an end-of-burst marker. At any moment one input is selected. Its valid, payload and end marker appear at the output, and the output reports which input that is. The downstream ready is routed back only to the selected input.

Two compile-time parameters shape the behaviour. The first picks how a free selection is made: the lowest-numbered requester wins, a rotating fair search starts just after the last served port, or ports are served strictly in turn (0, 1, ..., N-1, then 0 again). The second picks how long a selection is held: not at all (re-evaluated every cycle), until the stalled transfer is taken, or until a transfer carrying the end marker is taken. A transfer completes in a cycle where output valid and output ready are both high. Payload and end marker carry no meaning while valid is low.

Top module: `stream_arb_top`

## Requirements
- R1: Output valid, payload and end marker equal those of the input whose index is on `out_port`, in the same cycle; a transfer completes when `out_valid` and `out_ready` are both high.
- R2: With lowest-index policy and no hold active, `out_port` is the lowest-numbered input with valid high, or 0 when none is valid.
- R3: With the rotating policy and no hold active, the search begins at a pointer and takes the first valid input at or after it, wrapping; with none valid, `out_port` shows the pointer. After each completion (a completion with the end marker set when burst hold is chosen) the pointer moves to the port after the one served.
- R4: With the in-turn policy, `out_port` always shows the expected port, which starts at 0 and advances by one with wrap after each completion (end-marker completion under burst hold); `out_valid` stays low until that port is valid, and no other port is ever served.
- R5: With no hold, the selection is re-evaluated every cycle, so a stalled transfer may be abandoned and the output payload may change while valid is high and ready is low.
- R6: With transfer hold, once the output is valid and not ready the selection does not change until a transfer completes on that port.
- R7: With burst hold, once the selected port presents valid, the selection stays on it until a transfer with the end marker set completes there, including across cycles where that port's valid is low.
- R8: `in_ready[i]` is high only when `out_ready` is high and `out_port` equals i; at most one bit of `in_ready` is high.
- R9: Synchronous active-high reset releases any hold and returns the rotating and in-turn pointers to port 0.
- R10: `out_port` reports the index of the selected input as an unsigned binary number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | N_PORTS | Per-input valid, bit i for input i |
| in_data | input | N_PORTS*DATA_W | Payloads, input i in bits [i*DATA_W +: DATA_W] |
| in_last | input | N_PORTS | Per-input end-of-burst marker |
| in_ready | output | N_PORTS | Per-input ready, bit i for input i |
| out_valid | output | 1 | Selected input's valid |
| out_data | output | DATA_W | Selected input's payload |
| out_last | output | 1 | Selected input's end marker |
| out_port | output | $clog2(N_PORTS) | Index of the selected input |
| out_ready | input | 1 | Downstream ready |

## Verification
A wrong pointer or a stale hold register shows up at `out_port` in the very next cycle in which the correct and the wrong choice differ, which the per-cycle comparison catches as soon as the requesting pattern separates them. A hold released too early shows as a port change during a stall or in the middle of a burst, and a hold that sticks shows as the output ignoring a valid port that should win. Routing errors appear at once as a wrong `in_ready` bit or a payload that does not belong to the reported port.

// File: rtl/stream_arb_pkg.sv
`timescale 1ns/1ps
package stream_arb_pkg;

    // How a free selection is chosen
    typedef enum logic [1:0] {
        ARB_FIXED    = 2'd0,   // lowest index wins
        ARB_ROTATE   = 2'd1,   // fair rotating search
        ARB_SEQUENCE = 2'd2    // strict port order
    } arb_mode_e;

    // How long a selection is held
    typedef enum logic [1:0] {
        HOLD_NONE  = 2'd0,
        HOLD_XFER  = 2'd1,
        HOLD_BURST = 2'd2
    } hold_mode_e;

    // Next port index with wrap
    function automatic int wrap_next(input int idx, input int count);
        return (idx + 1 >= count) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/arb_pick.sv
`timescale 1ns/1ps
module arb_pick
    import stream_arb_pkg::*;
#(
    parameter int        N_PORTS = 4,
    parameter int        IDX_W   = 2,
    parameter arb_mode_e MODE    = ARB_ROTATE
) (
    input  logic [N_PORTS-1:0] req,
    input  logic [IDX_W-1:0]   start,
    output logic [IDX_W-1:0]   pick
);

    generate
        if (MODE == ARB_FIXED) begin : g_fixed
            // start stays 0 in this mode; used as the idle choice
            always_comb begin
                pick = start;
                for (int i = N_PORTS - 1; i >= 0; i--) begin
                    if (req[i]) pick = IDX_W'(i);
                end
            end
        end else if (MODE == ARB_ROTATE) begin : g_rotate
            always_comb begin
                logic found;
                int   idx;
                pick  = start;
                found = 1'b0;
                for (int i = 0; i < N_PORTS; i++) begin
                    idx = int'(start) + i;
                    if (idx >= N_PORTS) idx = idx - N_PORTS;
                    if (!found && req[idx]) begin
                        pick  = IDX_W'(idx);
                        found = 1'b1;
                    end
                end
            end
        end else begin : g_sequence
            logic unused_req;
            assign unused_req = ^req;
            assign pick = start;
        end
    endgenerate

endmodule

// File: rtl/arb_state.sv
`timescale 1ns/1ps
module arb_state
    import stream_arb_pkg::*;
#(
    parameter int         N_PORTS = 4,
    parameter int         IDX_W   = 2,
    parameter arb_mode_e  ARB     = ARB_ROTATE,
    parameter hold_mode_e HOLD    = HOLD_BURST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] cand,
    input  logic             out_valid,
    input  logic             out_ready,
    input  logic             out_last,
    output logic [IDX_W-1:0] sel,
    output logic [IDX_W-1:0] ptr,
    output logic             locked
);

    logic [IDX_W-1:0] lock_idx;
    logic             fire;
    logic             done;
    logic             lock_n;

    assign fire = out_valid && out_ready;
    // completion of a unit: a transfer, or a burst under burst hold
    assign done = fire && (out_last || (HOLD != HOLD_BURST));
    assign sel  = locked ? lock_idx : cand;

    generate
        if (HOLD == HOLD_NONE) begin : g_nohold
            assign lock_n = 1'b0;
        end else begin : g_hold
            assign lock_n = (locked || out_valid) && !done;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            locked   <= 1'b0;
            lock_idx <= '0;
            ptr      <= '0;
        end else begin
            locked <= lock_n;
            if (!locked) lock_idx <= sel;
            if (done && (ARB != ARB_FIXED))
                ptr <= IDX_W'(wrap_next(int'(sel), N_PORTS));
        end
    end

    // R9: reset releases hold and rewinds the pointer
    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (ptr == '0) && !locked);

endmodule

// File: rtl/stream_arb_top.sv
`timescale 1ns/1ps
module stream_arb_top
    import stream_arb_pkg::*;
#(
    parameter int         N_PORTS = 4,
    parameter int         DATA_W  = 8,
    parameter arb_mode_e  ARB     = ARB_ROTATE,
    parameter hold_mode_e HOLD    = HOLD_BURST
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_PORTS-1:0]           in_valid,
    input  logic [N_PORTS*DATA_W-1:0]    in_data,
    input  logic [N_PORTS-1:0]           in_last,
    output logic [N_PORTS-1:0]           in_ready,
    output logic                         out_valid,
    output logic [DATA_W-1:0]            out_data,
    output logic                         out_last,
    output logic [$clog2(N_PORTS)-1:0]   out_port,
    input  logic                         out_ready
);

    localparam int IDX_W = $clog2(N_PORTS);

    logic [IDX_W-1:0] cand;
    logic [IDX_W-1:0] sel;
    logic [IDX_W-1:0] ptr;
    logic             locked;

    arb_pick #(
        .N_PORTS (N_PORTS),
        .IDX_W   (IDX_W),
        .MODE    (ARB)
    ) u_pick (
        .req   (in_valid),
        .start (ptr),
        .pick  (cand)
    );

    arb_state #(
        .N_PORTS (N_PORTS),
        .IDX_W   (IDX_W),
        .ARB     (ARB),
        .HOLD    (HOLD)
    ) u_state (
        .clk       (clk),
        .rst       (rst),
        .cand      (cand),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_last  (out_last),
        .sel       (sel),
        .ptr       (ptr),
        .locked    (locked)
    );

    assign out_port  = sel;
    assign out_valid = in_valid[sel];
    assign out_last  = in_last[sel];
    assign out_data  = in_data[sel*DATA_W +: DATA_W];

    generate
        for (genvar i = 0; i < N_PORTS; i++) begin : g_ready
            assign in_ready[i] = out_ready && (sel == IDX_W'(i));
        end
    endgenerate

    // R8: ready goes back to one port at most, only when downstream is ready
    assert_ready_route_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_ready) && ((in_ready == '0) || out_ready));

    generate
        if (ARB == ARB_FIXED) begin : g_chk_fixed
            // R2: no lower-numbered port is waiting while a free choice is made
            assert_lowest_wins_R2: assert property (@(posedge clk) disable iff (rst)
                (out_valid && !locked) |->
                ((in_valid & ((N_PORTS'(1) << out_port) - N_PORTS'(1))) == '0));
        end
        if (ARB == ARB_SEQUENCE) begin : g_chk_seq
            // R4: after a completed unit the expected port steps by one
            assert_turn_advance_R4: assert property (@(posedge clk) disable iff (rst)
                (out_valid && out_ready && (out_last || (HOLD != HOLD_BURST))) |=>
                (out_port == (($past(out_port) == IDX_W'(N_PORTS - 1)) ?
                              IDX_W'(0) : $past(out_port) + IDX_W'(1))));
        end
        if (HOLD != HOLD_NONE) begin : g_chk_stall
            // R6: a stall keeps the selection
            assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
                (out_valid && !out_ready) |=> (out_port == $past(out_port)));
        end
        if (HOLD == HOLD_BURST) begin : g_chk_burst
            // R7: a mid-burst transfer keeps the selection
            assert_burst_hold_R7: assert property (@(posedge clk) disable iff (rst)
                (out_valid && out_ready && !out_last) |=> (out_port == $past(out_port)));
        end
    endgenerate

endmodule

// File: tb/stream_arb_top_tb.sv
`timescale 1ns/1ps
module stream_arb_top_tb;
    import stream_arb_pkg::*;

    localparam int N = 4;
    localparam int W = 8;
    localparam int K = 4;
    localparam arb_mode_e  ARBS  [K] = '{ARB_FIXED, ARB_ROTATE, ARB_SEQUENCE, ARB_ROTATE};
    localparam hold_mode_e HOLDS [K] = '{HOLD_NONE, HOLD_XFER, HOLD_BURST, HOLD_BURST};

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [N-1:0]   iv = '0;
    logic [N*W-1:0] id = '0;
    logic [N-1:0]   il = '0;
    logic [K-1:0]   ordy = '0;
    logic [K-1:0]   ov;
    logic [K-1:0]   ol;
    logic [W-1:0]   od   [K];
    logic [1:0]     op   [K];
    logic [N-1:0]   irdy [K];

    generate
        for (genvar g = 0; g < K; g++) begin : g_dut
            stream_arb_top #(
                .N_PORTS (N),
                .DATA_W  (W),
                .ARB     (ARBS[g]),
                .HOLD    (HOLDS[g])
            ) u_dut (
                .clk       (clk),
                .rst       (rst),
                .in_valid  (iv),
                .in_data   (id),
                .in_last   (il),
                .in_ready  (irdy[g]),
                .out_valid (ov[g]),
                .out_data  (od[g]),
                .out_last  (ol[g]),
                .out_port  (op[g]),
                .out_ready (ordy[g])
            );
        end
    endgenerate

    // reference model state
    int m_lock [K];
    int m_lidx [K];
    int m_ptr  [K];
    int n_lock [K];
    int n_lidx [K];
    int n_ptr  [K];

    int  checks   = 0;
    int  failures = 0;
    bit  finished = 1'b0;

    function automatic string port_tag(input int k);
        case (k)
            0: return "R2 R5 R10";
            1: return "R3 R6 R10";
            2: return "R4 R7 R10";
            default: return "R3 R7 R10";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int k, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s dut%0d: actual=%0d expected=%0d at %0t", tag, k, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < K; k++) begin
            m_lock[k] = 0; m_lidx[k] = 0; m_ptr[k] = 0;
        end
    endtask

    // compare now, then advance the model across the next rising edge
    task automatic eval_and_step();
        for (int k = 0; k < K; k++) begin
            int cand, sel, ev, done;
            logic [N-1:0] er;
            cand = m_ptr[k];
            if (ARBS[k] == ARB_FIXED) begin
                cand = 0;
                for (int i = N - 1; i >= 0; i--) if (iv[i]) cand = i;
            end else if (ARBS[k] == ARB_ROTATE) begin
                for (int i = N - 1; i >= 0; i--)
                    if (iv[(m_ptr[k] + i) % N]) cand = (m_ptr[k] + i) % N;
            end
            sel = (m_lock[k] != 0) ? m_lidx[k] : cand;
            ev  = iv[sel];
            chk(op[k] == 2'(sel), port_tag(k), k, op[k], sel);
            chk(ov[k] == ev[0], "R1 valid", k, ov[k], ev);
            if (ev != 0) begin
                chk(od[k] == id[sel*W +: W], "R1 data", k, od[k], id[sel*W +: W]);
                chk(ol[k] == il[sel], "R1 last", k, ol[k], il[sel]);
            end
            er = '0;
            if (ordy[k]) er[sel] = 1'b1;
            chk(irdy[k] == er, "R8 ready", k, irdy[k], er);
            done = (ev != 0) && ordy[k] && ((HOLDS[k] != HOLD_BURST) || il[sel]);
            n_lock[k] = (HOLDS[k] == HOLD_NONE) ? 0 :
                        (((m_lock[k] != 0) || (ev != 0)) && (done == 0)) ? 1 : 0;
            n_lidx[k] = (m_lock[k] != 0) ? m_lidx[k] : sel;
            n_ptr[k]  = ((done != 0) && (ARBS[k] != ARB_FIXED)) ? (sel + 1) % N : m_ptr[k];
        end
        @(posedge clk);
        #1;
        for (int k = 0; k < K; k++) begin
            m_lock[k] = n_lock[k]; m_lidx[k] = n_lidx[k]; m_ptr[k] = n_ptr[k];
        end
    endtask

    task automatic run_phase(input int cycles, input int vprob, input int rprob, input int lprob);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                iv[i] = ($urandom_range(99) < vprob);
                il[i] = ($urandom_range(99) < lprob);
                id[i*W +: W] = W'($urandom);
            end
            for (int k = 0; k < K; k++) ordy[k] = ($urandom_range(99) < rprob);
            #5;
            eval_and_step();
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R9: port 0 idle, others valid; in-turn must wait on port 0
        iv = 4'b1110;
        il = 4'b1111;
        ordy = '1;
        #5;
        chk(op[2] == 2'd0, "R9 seq pointer", 2, op[2], 0);
        chk(ov[2] == 1'b0, "R9 R4 seq waits", 2, ov[2], 0);
        chk(op[1] == 2'd1, "R9 rotate pointer", 1, op[1], 1);
        chk(op[0] == 2'd1, "R9 R2 fixed choice", 0, op[0], 1);
        eval_and_step();
    endtask

    initial begin
        void'($urandom(32'd1234));
        apply_reset();
        run_phase(2000, 90, 70, 30);
        run_phase(2000, 70, 20, 40);
        run_phase(2000, 25, 80, 50);
        apply_reset();
        run_phase(2000, 60, 50, 25);
        run_phase(1000, 100, 100, 20);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

endmodule